// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the timing core of a master on a single-wire, open-drain bus with an external pull-up. A host issues one command at a time: a bus reset with a presence check, a one-bit write, or a one-bit read. The engine pulls the line low or releases it by a fixed timetable and samples the returned level at a fixed point. It then reports completion with a one-clock done pulse, together with the presence flag or the read bit.

All timing is counted in microseconds. A divider turns the system clock into microseconds, and `CLK_PER_US` sets the number of clocks in each. The line input passes through a two-flop synchronizer before any sample is taken. The engine handles only single bits and reset sequences. Byte assembly, addressing and checksums belong to the layers above it.

Top module: `onewire_master`

## Requirements
- R1: A reset command (cmd_op = 0) holds drive_low high for 480 us, starting in the cycle after acceptance. It then releases the line, and done pulses 960 us after acceptance. One microsecond is CLK_PER_US clock cycles.
- R2: During a reset, the synchronized line is sampled 70 us after the release (550 us after acceptance). presence becomes 1 if the line was low at that point and 0 otherwise. The value holds until the next reset.
- R3: A write command (cmd_op = 1) drives the line low for 2 us when cmd_wbit = 1 and for 65 us when cmd_wbit = 0. done pulses 70 us after acceptance, which is a 65 us slot plus 5 us of recovery.
- R4: A read command (cmd_op = 2) drives the line low for 2 us and samples the synchronized line 13 us after acceptance. rd_bit takes the sampled level and holds until the next read. done pulses 70 us after acceptance.
- R5: busy is high from the cycle after acceptance until the cycle in which done is high. done is high for exactly one clock per operation, and drive_low is never high while busy is low.
- R6: A command presented while busy is ignored and does not change the running operation's timing. cmd_op = 3 is ignored at all times.
- R7: After reset, busy, done, drive_low, presence and rd_bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 no operation |
| cmd_wbit | input | 1 | Bit value for a write command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A slave answered the last reset |
| rd_bit | output | 1 | Bit returned by the last read |
| line_in | input | 1 | Level of the bus line |
| drive_low | output | 1 | Enable for the open-drain pull-down |

## Verification
The assertions assume that the host only considers done and the result outputs after acceptance, and that cmd_op is one of the four listed codes. The assertions also assume that line_in may change at any time, since it is synchronized. The bench slave model drives the line only inside windows that are aligned to the command start: a read-0 pull between 3 us and 40 us, and a presence pull between 30 us and 150 us after the reset release. Each window stays clear of the sample points by many clocks, so synchronizer latency never decides a result. Random commands are presented only while the engine is idle, except for deliberate pokes that test R6.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } owm_op_e;
endpackage

// File: rtl/owm_sync2.sv
module owm_sync2 #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= IDLE_LEVEL;
      q    <= IDLE_LEVEL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div <= '0;
    end else if (div == LAST) begin
      div <= '0;
    end else begin
      div <= div + 1'b1;
    end
  end

  assign tick = (div == LAST);

  a_r1_div_in_range: assert property (@(posedge clk) disable iff (rst)
    div <= LAST);
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW_US     = 480,
  parameter int RST_TOTAL_US   = 960,
  parameter int PRES_SAMPLE_US = 550,
  parameter int SHORT_LOW_US   = 2,
  parameter int READ_SAMPLE_US = 13,
  parameter int SLOT_US        = 65,
  parameter int RECOVERY_US    = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  owm_op_e start_op,
  input  logic    start_bit,
  input  logic    tick,
  input  logic    line_s,
  output logic    busy,
  output logic    done,
  output logic    drive_low,
  output logic    presence,
  output logic    rd_bit
);
  localparam int SLOT_TOTAL_US = SLOT_US + RECOVERY_US;
  localparam int MAX_US = (RST_TOTAL_US > SLOT_TOTAL_US) ? RST_TOTAL_US : SLOT_TOTAL_US;
  localparam int UW = $clog2(MAX_US + 1);

  owm_op_e       cur_op;
  logic          cur_bit;
  logic [UW-1:0] ucnt;
  logic [UW-1:0] ucnt_nx;
  logic [UW-1:0] low_end;
  logic [UW-1:0] total_end;

  assign ucnt_nx = ucnt + 1'b1;

  always_comb begin
    case (cur_op)
      OP_RESET: begin
        low_end   = UW'(RST_LOW_US);
        total_end = UW'(RST_TOTAL_US);
      end
      OP_WRITE: begin
        low_end   = cur_bit ? UW'(SHORT_LOW_US) : UW'(SLOT_US);
        total_end = UW'(SLOT_TOTAL_US);
      end
      default: begin
        low_end   = UW'(SHORT_LOW_US);
        total_end = UW'(SLOT_TOTAL_US);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      drive_low <= 1'b0;
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
      cur_op    <= OP_NONE;
      cur_bit   <= 1'b0;
      ucnt      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          cur_op    <= start_op;
          cur_bit   <= start_bit;
          ucnt      <= '0;
          drive_low <= 1'b1;
        end
      end else if (tick) begin
        ucnt <= ucnt_nx;
        if (ucnt_nx == low_end) begin
          drive_low <= 1'b0;
        end
        if (cur_op == OP_READ && ucnt_nx == UW'(READ_SAMPLE_US)) begin
          rd_bit <= line_s;
        end
        if (cur_op == OP_RESET && ucnt_nx == UW'(PRES_SAMPLE_US)) begin
          presence <= ~line_s;
        end
        if (ucnt_nx == total_end) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          drive_low <= 1'b0;
        end
      end
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r5_drive_only_busy: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy);
  a_r1_drive_begins_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> $past(start));
  a_r6_op_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cur_op) && $stable(cur_bit)));
  a_r4_rd_bit_only_in_read: assert property (@(posedge clk) disable iff (rst)
    !(busy && cur_op == OP_READ) |=> $stable(rd_bit));
  a_r2_presence_only_in_reset: assert property (@(posedge clk) disable iff (rst)
    !(busy && cur_op == OP_RESET) |=> $stable(presence));
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US     = 50,
  parameter int RST_LOW_US     = 480,
  parameter int RST_TOTAL_US   = 960,
  parameter int PRES_SAMPLE_US = 550,
  parameter int SHORT_LOW_US   = 2,
  parameter int READ_SAMPLE_US = 13,
  parameter int SLOT_US        = 65,
  parameter int RECOVERY_US    = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  input  logic       line_in,
  output logic       drive_low
);
  owm_op_e op_in;
  logic    accept;
  logic    tick;
  logic    line_s;

  assign op_in  = owm_op_e'(cmd_op);
  assign accept = cmd_valid && !busy && (op_in != OP_NONE);

  owm_sync2 #(.IDLE_LEVEL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .tick  (tick)
  );

  owm_slot_engine #(
    .RST_LOW_US     (RST_LOW_US),
    .RST_TOTAL_US   (RST_TOTAL_US),
    .PRES_SAMPLE_US (PRES_SAMPLE_US),
    .SHORT_LOW_US   (SHORT_LOW_US),
    .READ_SAMPLE_US (READ_SAMPLE_US),
    .SLOT_US        (SLOT_US),
    .RECOVERY_US    (RECOVERY_US)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_op  (op_in),
    .start_bit (cmd_wbit),
    .tick      (tick),
    .line_s    (line_s),
    .busy      (busy),
    .done      (done),
    .drive_low (drive_low),
    .presence  (presence),
    .rd_bit    (rd_bit)
  );

  a_r6_noop_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd_valid && op_in != OP_NONE)) |=> !busy);
endmodule

// File: tb/test_onewire_master.sv
`timescale 1ns/100ps
module test_onewire_master;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic       cmd_wbit = 1'b0;
  logic       busy, done, presence, rd_bit, drive_low;
  logic       line_in;
  logic       slave_low = 1'b0;

  int cyc = 0;
  int t0 = 1000000;
  int slave_kind = 0;
  int compared = 0;
  int mismatched = 0;
  logic pres_model = 1'b0;
  logic rd_model = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_in = ~(drive_low | slave_low);

  onewire_master #(.CLK_PER_US(N)) i_onewire_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .busy(busy), .done(done), .presence(presence),
    .rd_bit(rd_bit), .line_in(line_in), .drive_low(drive_low)
  );

  always @(negedge clk) begin
    int dt;
    dt = cyc - t0;
    case (slave_kind)
      1: slave_low <= (dt >= 3*N) && (dt < 40*N);
      2: slave_low <= (dt >= 510*N) && (dt < 630*N);
      default: slave_low <= 1'b0;
    endcase
  end

  function automatic int exp_low(int op, int b);
    if (op == 0) return 480;
    if (op == 1) return b ? 2 : 65;
    return 2;
  endfunction

  function automatic int exp_total(int op);
    return (op == 0) ? 960 : 70;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(int op, int b, int act, bit poke);
    int lowcnt = 0, donecnt = 0, donetime = -1, busy0;
    int total;
    total = exp_total(op) * N;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_wbit = b[0];
    t0 = cyc + 1;
    slave_kind = (act != 0) ? ((op == 0) ? 2 : ((op == 2) ? 1 : 0)) : 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy0 = int'(busy);
    for (int m = 0; m <= total + 3; m++) begin
      if (drive_low) lowcnt++;
      if (done) begin donecnt++; donetime = m; end
      if (poke && m == 10) begin cmd_valid = 1'b1; cmd_op = 2'd0; cmd_wbit = 1'b0; end
      if (poke && m == 11) cmd_valid = 1'b0;
      @(negedge clk);
    end
    slave_kind = 0;
    if (op == 0) pres_model = (act != 0);
    if (op == 2) rd_model = (act == 0);
    chk("R5 busy after accept", busy0, 1);
    if (op == 0) chk("R1 reset low cycles", lowcnt, exp_low(op, b) * N);
    else if (op == 1) chk("R3 write low cycles", lowcnt, exp_low(op, b) * N);
    else chk("R4 read low cycles", lowcnt, exp_low(op, b) * N);
    chk(poke ? "R6 done time after poke" : "R1 R3 R4 done time", donetime, total);
    chk("R5 single done pulse", donecnt, 1);
    chk("R5 idle after done", int'(busy), 0);
    chk("R2 presence", int'(presence), int'(pres_model));
    chk("R4 read bit", int'(rd_bit), int'(rd_model));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R7 reset busy", int'(busy), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R7 reset drive", int'(drive_low), 0);
    chk("R7 reset presence", int'(presence), 0);
    chk("R7 reset rd_bit", int'(rd_bit), 0);

    // directed corners
    do_op(0, 0, 1, 1'b0);   // R2 slave answers
    do_op(0, 0, 0, 1'b0);   // R2 no answer
    do_op(0, 0, 1, 1'b0);
    do_op(1, 1, 0, 1'b0);   // R3 write one
    do_op(1, 0, 0, 1'b0);   // R3 write zero
    do_op(2, 0, 0, 1'b0);   // R4 read one
    do_op(2, 0, 1, 1'b0);   // R4 read zero
    do_op(2, 0, 0, 1'b1);   // R6 poke while busy

    // R6 no-operation code
    begin
      int seen = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (busy || drive_low || done) seen++;
        @(negedge clk);
      end
      chk("R6 noop ignored", seen, 0);
    end

    // random mix
    for (int i = 0; i < 28; i++) begin
      int op, b, act;
      op  = ((i % 12) == 5) ? 0 : 1 + int'($urandom_range(1, 0));
      b   = int'($urandom_range(1, 0));
      act = (op == 1) ? 0 : int'($urandom_range(1, 0));
      do_op(op, b, act, ($urandom_range(7, 0) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule